// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every cycle, which of several hardware thread contexts sharing one pipeline may issue. Instructions from different threads may therefore sit in the pipeline together. The goal is to keep the pipeline busy, at the cost of a longer latency for any single thread.

A run-time mode input selects one of two policies. In fine-grain mode the grant moves round-robin through the ready threads on every cycle. In coarse-grain mode a home thread keeps the pipeline. When the home thread signals a long-latency miss, issue moves to another thread. That thread stays in control until the home thread's miss is resolved and the home thread is ready again.

The grant is available combinationally in the same cycle as the inputs. It is given both as a one-hot vector and as a binary thread index, with a valid flag.

Top module: `thr_issue_sel`

## Requirements
- R1: After reset, the round-robin pointer and the coarse-mode current thread are both thread 0. With all threads ready and no miss, the first grant is thread 0 in either mode.
- R2: When `valid_o` is 1, `grant_o` has exactly one bit set, at the position of the binary index `grant_id_o`, and that thread's ready bit is 1. When `valid_o` is 0, `grant_o` is all zero.
- R3: When no thread is eligible, `valid_o` is 0. In fine mode a thread is eligible when its ready bit is 1.
- R4: Fine mode (`mode_i`=0) grants the first ready thread at or after the round-robin pointer, in increasing circular index order. The pointer moves to the granted index plus one (modulo the thread count) only on cycles with a fine-mode grant.
- R5: In fine mode, the miss and resolve inputs and the parked state have no effect on the grant.
- R6: In coarse mode (`mode_i`=1), the home thread (index 0) is granted whenever it is eligible. In coarse mode a thread is eligible when it is ready, not parked, and has no miss pulse in the current cycle.
- R7: A miss pulse on a thread excludes that thread from the coarse grant in the same cycle. The pulse also parks the thread. The thread stays parked until the cycle of a resolve pulse on it, and it can be granted again from the following cycle.
- R8: In coarse mode, when the home thread is not eligible, the grant stays on the last coarse-granted thread if that thread is eligible. Otherwise the grant goes to the next eligible thread after it in circular order. The current-thread register changes only on coarse-mode grants.
- R9: A miss and a resolve pulse on the same thread in the same cycle leave the thread parked.
- R10: The mode may change on any cycle. The pointer, the current thread and the parked state are kept across a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = fine-grain rotation, 1 = coarse-grain home thread |
| ready_i | input | NUM_THR | Per-thread ready to issue |
| miss_i | input | NUM_THR | Per-thread long-latency miss pulse |
| resolved_i | input | NUM_THR | Per-thread miss-resolved pulse |
| grant_o | output | NUM_THR | One-hot issue grant |
| grant_id_o | output | $clog2(NUM_THR) | Binary index of the granted thread |
| valid_o | output | 1 | A thread is granted this cycle |

## Verification
The bench uses the default build: four threads with thread 0 as home. With only four contexts, random ready masks often reach the cases that matter: a single ready thread, no ready thread, and wrap-around of the pointer from index 3 to 0. Short random bursts of miss and resolve pulses, together with frequent mode flips, make it likely that all threads are parked at once, that a miss and a resolve coincide on one thread, and that the home thread returns while another thread holds the pipeline.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  typedef enum logic {
    SEL_FINE   = 1'b0,
    SEL_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/thr_rr_pick.sv
// First requester at or after start_i, circular order.
module thr_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] start_i,
  output logic          hit_o,
  output logic [IW-1:0] id_o
);
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(start_i) + k;
      if (idx >= N) idx = idx - N;
      if (!hit_o && req_i[idx]) begin
        hit_o = 1'b1;
        id_o  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/thr_park_track.sv
// Per-thread outstanding-miss flags; a miss beats a same-cycle resolve.
module thr_park_track #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] miss_i,
  input  logic [N-1:0] resolved_i,
  output logic [N-1:0] parked_o
);
  for (genvar t = 0; t < N; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) parked_o[t] <= 1'b0;
      else         parked_o[t] <= miss_i[t] | (parked_o[t] & ~resolved_i[t]);
    end
  end
endmodule

// File: rtl/thr_issue_sel.sv
module thr_issue_sel
  import thr_sel_pkg::*;
#(
  parameter int NUM_THR  = 4,
  parameter int HOME_TID = 0,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [NUM_THR-1:0] ready_i,
  input  logic [NUM_THR-1:0] miss_i,
  input  logic [NUM_THR-1:0] resolved_i,
  output logic [NUM_THR-1:0] grant_o,
  output logic [TID_W-1:0]   grant_id_o,
  output logic               valid_o
);
  localparam logic [TID_W-1:0] HOME_ID = TID_W'(HOME_TID);
  localparam logic [TID_W-1:0] LAST_ID = TID_W'(NUM_THR - 1);

  logic [TID_W-1:0]   rr_ptr_q, cur_q;
  logic [NUM_THR-1:0] parked_q, elig_c;
  logic               f_hit, c_hit;
  logic [TID_W-1:0]   f_id, c_id;
  logic               coarse;

  assign coarse = (mode_i == SEL_COARSE);

  thr_park_track #(.N(NUM_THR)) u_park (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .miss_i     (miss_i),
    .resolved_i (resolved_i),
    .parked_o   (parked_q)
  );

  // a thread missing this cycle yields at once
  assign elig_c = ready_i & ~parked_q & ~miss_i;

  thr_rr_pick #(.N(NUM_THR)) u_fine (
    .req_i   (ready_i),
    .start_i (rr_ptr_q),
    .hit_o   (f_hit),
    .id_o    (f_id)
  );

  // starting at cur_q keeps the current owner when it is eligible
  thr_rr_pick #(.N(NUM_THR)) u_coarse (
    .req_i   (elig_c),
    .start_i (cur_q),
    .hit_o   (c_hit),
    .id_o    (c_id)
  );

  always_comb begin
    if (coarse) begin
      if (elig_c[HOME_TID]) begin
        valid_o    = 1'b1;
        grant_id_o = HOME_ID;
      end else begin
        valid_o    = c_hit;
        grant_id_o = c_id;
      end
    end else begin
      valid_o    = f_hit;
      grant_id_o = f_id;
    end
    grant_o = valid_o ? (NUM_THR'(1) << grant_id_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_ptr_q <= '0;
      cur_q    <= HOME_ID;
    end else if (valid_o) begin
      if (coarse) cur_q <= grant_id_o;
      else        rr_ptr_q <= (grant_id_o == LAST_ID) ? '0 : grant_id_o + 1'b1;
    end
  end

  // checks
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($onehot(grant_o) && grant_o[grant_id_o])); // R2
  AST_GRANT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((grant_o & ready_i) != '0)); // R2
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i == '0) |-> (!valid_o && grant_o == '0)); // R3
  AST_FINE_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !coarse && $past(mode_i) == SEL_FINE && $past(valid_o) && (&ready_i))
      |-> grant_id_o == (($past(grant_id_o) == LAST_ID) ? '0 : $past(grant_id_o) + 1'b1)); // R4
  AST_MISS_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse |-> ((grant_o & miss_i) == '0)); // R7
  AST_MISS_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && coarse) |-> ((grant_o & $past(miss_i)) == '0)); // R9
endmodule

// File: tb/sim_thr_issue_sel.sv
module sim_thr_issue_sel;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic [N-1:0] ready_i = '0, miss_i = '0, resolved_i = '0;
  logic [N-1:0] grant_o;
  logic [1:0]   grant_id_o;
  logic         valid_o;

  int checks = 0, errors = 0;
  int m_rr = 0, m_cur = 0;
  logic [N-1:0] m_park = '0;

  always #4 clk_i = ~clk_i;

  thr_issue_sel #(.NUM_THR(N), .HOME_TID(0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .ready_i(ready_i),
    .miss_i(miss_i), .resolved_i(resolved_i), .grant_o(grant_o),
    .grant_id_o(grant_id_o), .valid_o(valid_o)
  );

  function automatic int pick_ref(logic [N-1:0] req, int start);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (start + k) % N;
      if (req[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic int expect_id(logic md, logic [N-1:0] rdy, logic [N-1:0] ms);
    logic [N-1:0] el;
    if (!md) return pick_ref(rdy, m_rr);
    el = rdy & ~m_park & ~ms;
    if (el[0]) return 0;
    return pick_ref(el, m_cur);
  endfunction

  // drive at negedge, compare mid-low phase, advance the model
  task automatic step(logic md, logic [N-1:0] rdy, logic [N-1:0] ms,
                      logic [N-1:0] rs, string tag, int lit = -2);
    int e;
    logic [N-1:0] eg;
    @(negedge clk_i);
    mode_i = md; ready_i = rdy; miss_i = ms; resolved_i = rs;
    #2;
    e  = expect_id(md, rdy, ms);
    eg = (e < 0) ? '0 : (N'(1) << e);
    checks++;
    if (valid_o !== (e >= 0) || grant_o !== eg ||
        (e >= 0 && int'(grant_id_o) != e) || (lit != -2 && lit != e)) begin
      errors++;
      $display("FAIL %s: valid=%0b grant=%b id=%0d expected valid=%0b grant=%b id=%0d",
               tag, valid_o, grant_o, grant_id_o, (e >= 0), eg, (lit != -2) ? lit : e);
    end
    if (e >= 0) begin
      if (md) m_cur = e;
      else    m_rr = (e + 1) % N;
    end
    m_park = ms | (m_park & ~rs);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    #1;
    checks++;
    if (valid_o !== 1'b0 || grant_o !== '0) begin
      errors++;
      $display("FAIL R3: in reset valid=%0b grant=%b expected 0/0000", valid_o, grant_o);
    end
    rst_ni = 1'b1;
    // R1 reset state
    step(1'b0, 4'hF, 4'h0, 4'h0, "R1", 0);
    // R4 rotation with wrap
    step(1'b0, 4'hF, 4'h0, 4'h0, "R4", 1);
    step(1'b0, 4'hF, 4'h0, 4'h0, "R4", 2);
    step(1'b0, 4'hF, 4'h0, 4'h0, "R4", 3);
    step(1'b0, 4'hF, 4'h0, 4'h0, "R4", 0);
    step(1'b0, 4'b1010, 4'h0, 4'h0, "R4", 1);
    step(1'b0, 4'b0001, 4'h0, 4'h0, "R4", 0);
    // R3 nobody ready, pointer must hold at 1
    step(1'b0, 4'h0, 4'h0, 4'h0, "R3", -1);
    step(1'b0, 4'hF, 4'h0, 4'h0, "R4", 1);
    // R5 miss in fine mode ignored; thread 2 parks
    step(1'b0, 4'hF, 4'b0100, 4'h0, "R5", 2);
    step(1'b0, 4'hF, 4'h0, 4'h0, "R5", 3);
    // R10 switch to coarse: thread 2 still parked, home wins (R6)
    step(1'b1, 4'hF, 4'h0, 4'h0, "R6", 0);
    // R7 home misses: yields at once to thread 1
    step(1'b1, 4'hF, 4'b0001, 4'h0, "R7", 1);
    // R8 sticky on 1
    step(1'b1, 4'hF, 4'h0, 4'h0, "R8", 1);
    step(1'b1, 4'b1101, 4'h0, 4'h0, "R8", 3);
    step(1'b1, 4'hF, 4'h0, 4'h0, "R8", 3);
    // R9 resolve and miss together on home: stays parked
    step(1'b1, 4'hF, 4'b0001, 4'b0001, "R9", 3);
    step(1'b1, 4'hF, 4'h0, 4'h0, "R9", 3);
    // R7 resolve home: return next cycle
    step(1'b1, 4'hF, 4'h0, 4'b0001, "R7", 3);
    step(1'b1, 4'hF, 4'h0, 4'h0, "R7", 0);
    // R3 coarse with all eligible threads parked or missing
    step(1'b1, 4'b0101, 4'b0001, 4'h0, "R3", -1);
    step(1'b1, 4'b0101, 4'h0, 4'b0101, "R3", -1);
    step(1'b1, 4'b0101, 4'h0, 4'h0, "R6", 0);
    // R10 back to fine, pointer kept at 0
    step(1'b0, 4'hF, 4'h0, 4'h0, "R10", 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic md;
      logic [N-1:0] rdy, ms, rs;
      md  = ($urandom % 8) < 4 ? mode_i : ~mode_i;
      rdy = ($urandom % 10 == 0) ? 4'h0 : N'($urandom);
      ms  = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : 4'h0;
      rs  = ($urandom % 3 == 0) ? N'($urandom) : 4'h0;
      step(md, rdy, ms, rs, md ? "R8" : "R4");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule